// File: doc/BRIEF.md
# Up/Down Trim Counter Controller

This block is the digital control core of a 128-position trimmer. It runs on a system clock and samples three asynchronous control pins: an active-low select, an increment strobe and a direction pin. A 7-bit setting register drives the code of an external DAC. Each falling edge of the strobe while the block is selected moves the setting one position up or down, and the setting stops at either end of its range instead of wrapping.

At power-up the block asks a nonvolatile store port for the saved setting and loads it before it accepts any adjustment. When the host deselects the block, the level of the strobe at that moment decides whether the setting is committed. A high strobe issues a one-cycle write request and holds a busy flag for the write time. A low strobe keeps the setting only until the next power cycle. If the store reports a failed write, a sticky error flag rises and the block keeps working as a volatile register.

Top module: `trim_ctrl`

## Requirements
- R1: While reset is asserted, dac_code is 0 and ready, busy, wear_err and nv_wr_req are all 0. Select and increment read as high, so neither a step nor a store can occur.
- R2: After reset, nv_rd_req stays high until nv_rd_ack arrives. In that cycle dac_code takes nv_rd_data and ready rises and then stays high. Strobe activity before ready has no effect on the setting.
- R3: With sel_n low and dir high (1 = up), each falling edge of inc raises dac_code by exactly one. The new code appears on the third rising clock edge after the pin edge.
- R4: With sel_n low and dir low (0 = down), each falling edge of inc lowers dac_code by exactly one.
- R5: The setting saturates: a step up at 127 leaves it at 127, and a step down at 0 leaves it at 0.
- R6: While sel_n is high, inc and dir are ignored and dac_code holds its value.
- R7: A rising edge of sel_n while inc is high, with no write in progress, produces a single-cycle nv_wr_req with nv_wr_data equal to the current dac_code.
- R8: A rising edge of sel_n while inc is low issues no write and leaves dac_code unchanged. The next recall then returns the previously saved value.
- R9: busy is high for exactly WRITE_CYCLES clock cycles after a write request. A deselect with inc high while busy is high starts no write.
- R10: If nv_wr_fail is high while busy is high, wear_err rises and stays high until reset. Stepping keeps working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel_n | input | 1 | Active-low select, asynchronous |
| inc | input | 1 | Step strobe; a falling edge steps the setting |
| dir | input | 1 | Step direction: 1 = up, 0 = down |
| nv_rd_req | output | 1 | Recall request to the nonvolatile store |
| nv_rd_ack | input | 1 | Recall data valid |
| nv_rd_data | input | WIDTH | Recalled setting |
| nv_wr_req | output | 1 | Single-cycle write request |
| nv_wr_data | output | WIDTH | Setting to be written |
| nv_wr_fail | input | 1 | Write failure (wear-out) report from the store |
| dac_code | output | WIDTH | Current setting, drives the DAC |
| ready | output | 1 | Recall done; adjustments accepted |
| busy | output | 1 | Write cycle in progress |
| wear_err | output | 1 | Sticky write-failure flag |

## Verification
A pin edge passes through two synchronizer flops and one edge-detect flop. A step therefore appears on dac_code at the third rising edge after the strobe falls, and a write request and busy appear at the third edge after select rises. The bench changes pins on falling clock edges and waits four full cycles before it samples, also on a falling edge, so every result has settled with a cycle of margin. The busy length is measured by a monitor that counts falling edges with busy high, so the WRITE_CYCLES check does not depend on when the stimulus happened.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int NPINS   = 3;
  localparam int IDX_SEL = 2;
  localparam int IDX_INC = 1;
  localparam int IDX_DIR = 0;

  typedef enum logic {
    NV_RECALL = 1'b0,
    NV_RUN    = 1'b1
  } nv_state_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] pins,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  // Two-stage synchronizer plus one history stage per pin; all reset high
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, cur_q, prev_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        cur_q  <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        meta_q <= pins[g];
        cur_q  <= meta_q;
        prev_q <= cur_q;
      end
    end
    assign cur[g]  = cur_q;
    assign prev[g] = prev_q;
  end
endmodule

// File: rtl/trim_step.sv
module trim_step #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load) begin
      code_d = load_val;
    end else if (step_en) begin
      if (step_up) begin
        if (code_q != TOP) code_d = code_q + 1'b1;
      end else begin
        if (code_q != BOT) code_d = code_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code = code_q;

  // R3/R4: outside a load, the code moves by at most one position per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(load) |-> (code_q == $past(code_q)) ||
                     (code_q == $past(code_q) + 1'b1) ||
                     (code_q == $past(code_q) - 1'b1));

  assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load && step_en && step_up && code_q == TOP) |=> code_q == TOP);

  assert_sat_bot_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load && step_en && !step_up && code_q == BOT) |=> code_q == BOT);
endmodule

// File: rtl/trim_nv.sv
module trim_nv
  import trim_pkg::*;
#(
  parameter int W            = 7,
  parameter int WRITE_CYCLES = 1_000_000
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         rd_ack,
  input  logic         store_req,
  input  logic [W-1:0] code,
  input  logic         wr_fail,
  output logic         rd_req,
  output logic         ready,
  output logic         wr_req,
  output logic [W-1:0] wr_data,
  output logic         busy,
  output logic         err
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WRITE_CYCLES);

  nv_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_req_q, wr_req_d;
  logic [W-1:0]  wr_data_q, wr_data_d;
  logic          err_q, err_d;
  logic          start;

  assign rd_req = (state_q == NV_RECALL);
  assign ready  = (state_q == NV_RUN);
  assign busy   = (cnt_q != '0);
  assign start  = ready && store_req && !busy;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wr_data_d = wr_data_q;
    wr_req_d  = start;
    err_d     = err_q | (busy & wr_fail);
    if (state_q == NV_RECALL && rd_ack) state_d = NV_RUN;
    if (start) begin
      cnt_d     = CNT_LOAD;
      wr_data_d = code;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= NV_RECALL;
      cnt_q     <= '0;
      wr_req_q  <= 1'b0;
      wr_data_q <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      wr_req_q  <= wr_req_d;
      wr_data_q <= wr_data_d;
      err_q     <= err_d;
    end
  end

  assign wr_req  = wr_req_q;
  assign wr_data = wr_data_q;
  assign err     = err_q;

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    ready |=> ready);

  assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_req_q |=> !wr_req_q);

  assert_no_store_busy_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_req_q |-> !$past(busy));

  assert_wr_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_req_q |-> busy);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int WIDTH        = 7,
  parameter int WRITE_CYCLES = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             inc,
  input  logic             dir,
  output logic             nv_rd_req,
  input  logic             nv_rd_ack,
  input  logic [WIDTH-1:0] nv_rd_data,
  output logic             nv_wr_req,
  output logic [WIDTH-1:0] nv_wr_data,
  input  logic             nv_wr_fail,
  output logic [WIDTH-1:0] dac_code,
  output logic             ready,
  output logic             busy,
  output logic             wear_err
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [NPINS-1:0] pin_s, pin_p;

  trim_sync #(.N(NPINS)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pins   ({sel_n, inc, dir}),
    .cur    (pin_s),
    .prev   (pin_p)
  );

  logic inc_fall, sel_rise, step_en, store_req, load;

  assign inc_fall  = pin_p[IDX_INC] & ~pin_s[IDX_INC];
  assign sel_rise  = ~pin_p[IDX_SEL] & pin_s[IDX_SEL];
  assign step_en   = ready & ~pin_s[IDX_SEL] & inc_fall;
  assign store_req = sel_rise & pin_s[IDX_INC];
  assign load      = nv_rd_req & nv_rd_ack;

  trim_step #(.W(WIDTH)) u_step (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (load),
    .load_val (nv_rd_data),
    .step_en  (step_en),
    .step_up  (pin_s[IDX_DIR]),
    .code     (dac_code)
  );

  trim_nv #(.W(WIDTH), .WRITE_CYCLES(WRITE_CYCLES)) u_nv (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .rd_ack    (nv_rd_ack),
    .store_req (store_req),
    .code      (dac_code),
    .wr_fail   (nv_wr_fail),
    .rd_req    (nv_rd_req),
    .ready     (ready),
    .wr_req    (nv_wr_req),
    .wr_data   (nv_wr_data),
    .busy      (busy),
    .err       (wear_err)
  );

  assert_standby_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ready && pin_s[IDX_SEL]) |=> $stable(dac_code));

  assert_discard_no_write_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(pin_s[IDX_SEL]) && !pin_s[IDX_INC]) |=> !nv_wr_req);

  assert_no_step_unready_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ready && !load) |=> $stable(dac_code));
endmodule

// File: tb/trim_ctrl_bench.sv
`timescale 1ns/1ps
module trim_ctrl_bench;
  localparam int W  = 7;
  localparam int WC = 40;

  logic         clk = 1'b0;
  logic         rst_n, sel_n, inc, dir;
  logic         nv_rd_req, nv_rd_ack, nv_wr_req, nv_wr_fail;
  logic [W-1:0] nv_rd_data, nv_wr_data, dac_code;
  logic         ready, busy, wear_err;

  logic [W-1:0] nv_mem;
  logic         wear_out;
  int           wr_count, busy_run, busy_last;
  int           n_vec, n_bad;

  always #2.5 clk = ~clk;

  trim_ctrl #(.WIDTH(W), .WRITE_CYCLES(WC)) u_trim_ctrl (
    .clk, .rst_n, .sel_n, .inc, .dir,
    .nv_rd_req, .nv_rd_ack, .nv_rd_data,
    .nv_wr_req, .nv_wr_data, .nv_wr_fail,
    .dac_code, .ready, .busy, .wear_err
  );

  // Nonvolatile store model and monitors, all on falling edges
  assign nv_rd_data = nv_mem;
  always @(negedge clk) begin
    nv_rd_ack <= nv_rd_req && !nv_rd_ack;
    if (nv_wr_req) begin
      wr_count <= wr_count + 1;
      if (!wear_out) nv_mem <= nv_wr_data;
    end
    if (busy) busy_run <= busy_run + 1;
    else if (busy_run != 0) begin
      busy_last <= busy_run;
      busy_run  <= 0;
    end
  end

  // {dir, expected code}, starting from a recalled value of 100
  localparam logic [7:0] VEC [8] = '{
    {1'b1, 7'd101}, {1'b1, 7'd102}, {1'b0, 7'd101}, {1'b1, 7'd102},
    {1'b0, 7'd101}, {1'b0, 7'd100}, {1'b0, 7'd99},  {1'b1, 7'd100}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    dir = d;
    cyc(2);
    inc = 1'b0;
    cyc(4);
    inc = 1'b1;
    cyc(4);
  endtask

  task automatic wrap_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    wrap_up();
  end

  initial begin
    n_vec = 0; n_bad = 0;
    wr_count = 0; busy_run = 0; busy_last = 0;
    nv_mem = 7'd100; wear_out = 1'b0; nv_rd_ack = 1'b0;
    rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; dir = 1'b1; nv_wr_fail = 1'b0;
    cyc(5);
    chk("R1 dac_code", dac_code, 0);
    chk("R1 ready", ready, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wear_err", wear_err, 0);
    chk("R1 nv_wr_req", nv_wr_req, 0);

    rst_n = 1'b1;
    cyc(10);
    chk("R2 ready", ready, 1);
    chk("R2 recall", dac_code, 100);

    // Vector table: R3 up and R4 down steps
    sel_n = 1'b0;
    cyc(4);
    foreach (VEC[i]) begin
      pulse(VEC[i][7]);
      chk(VEC[i][7] ? "R3 step up" : "R4 step down", dac_code, int'(VEC[i][6:0]));
    end

    // R5 saturation
    repeat (30) pulse(1'b1);
    chk("R5 top", dac_code, 127);
    pulse(1'b1);
    chk("R5 top hold", dac_code, 127);
    repeat (130) pulse(1'b0);
    chk("R5 bottom", dac_code, 0);
    pulse(1'b0);
    chk("R5 bottom hold", dac_code, 0);

    // R7 store on deselect with inc high
    repeat (5) pulse(1'b1);
    sel_n = 1'b1;
    cyc(4);
    chk("R7 write count", wr_count, 1);
    chk("R7 stored value", nv_mem, 5);
    chk("R9 busy", busy, 1);

    // R9 store attempt during busy
    sel_n = 1'b0;
    cyc(4);
    pulse(1'b1);
    sel_n = 1'b1;
    cyc(4);
    chk("R9 no write while busy", wr_count, 1);
    chk("R9 code", dac_code, 6);
    cyc(WC + 10);
    chk("R9 busy cleared", busy, 0);
    chk("R9 busy length", busy_last, WC);

    // R6 standby ignores strobe and direction
    pulse(1'b0);
    pulse(1'b1);
    pulse(1'b0);
    chk("R6 standby code", dac_code, 6);
    chk("R6 standby writes", wr_count, 1);

    // R8 deselect with inc low: no store
    sel_n = 1'b0;
    cyc(4);
    dir = 1'b1;
    cyc(2);
    inc = 1'b0;
    cyc(4);
    sel_n = 1'b1;
    cyc(4);
    inc = 1'b1;
    cyc(4);
    chk("R8 code kept", dac_code, 7);
    chk("R8 no write", wr_count, 1);

    // R2/R8 power cycle: strobes during reset ignored, old value recalled
    rst_n = 1'b0;
    sel_n = 1'b0;
    cyc(3);
    pulse(1'b1);
    pulse(1'b1);
    rst_n = 1'b1;
    cyc(10);
    chk("R8 old value recalled", dac_code, 5);
    chk("R2 strobes before ready", dac_code, 5);

    // R10 write failure
    cyc(4);
    pulse(1'b1);
    wear_out = 1'b1;
    sel_n = 1'b1;
    cyc(4);
    nv_wr_fail = 1'b1;
    cyc(2);
    nv_wr_fail = 1'b0;
    cyc(2);
    chk("R10 wear_err set", wear_err, 1);
    cyc(WC + 5);
    sel_n = 1'b0;
    cyc(4);
    pulse(1'b1);
    chk("R10 volatile stepping", dac_code, 7);
    chk("R10 wear_err sticky", wear_err, 1);
    chk("R10 nv unchanged", nv_mem, 5);

    wrap_up();
  end
endmodule